// File: doc/BRIEF.md
# Sparse Row-by-Column Matrix Multiplier

This block multiplies two small sparse integer matrices and produces the dense product. The left operand A is held row-compressed: a list of non-zero values in row order, a column index for each of them, and a pointer per row giving where that row's values start. The right operand B is held column-compressed: non-zero values in column order, a row index for each, and a pointer per column. Both are loaded through a single write port into internal vector stores, with up to 8x8 matrices and up to 32 non-zeros per operand.

A start pulse launches a walker that steps over each row of A, each stored non-zero in that row, each column of B and each stored non-zero in that column. It spends one clock per candidate pair. When the A column index equals the B row index, the signed product is added into the matching result cell. Zero elements are never visited, so the run length follows the data. When the walk ends, a one-cycle done pulse is given and the 8x8 result can be read through a combinational read port.

Top module: `spmm_csr_csc`

## Requirements
- R1: After reset `busy` and `done` are 0 and every result cell reads 0.
- R2: A write with `wr_en`=1 stores the low bits of `wr_data` at `wr_addr` in the vector chosen by `wr_sel`. The codes are 0 A values, 1 A column indices, 2 A row pointers, 3 B values, 4 B row indices and 5 B column pointers. Values keep 16 bits, indices keep 3 bits and pointers keep 6 bits. Pointer vectors hold DIM+1 entries, and the last entry is the non-zero count.
- R3: After a run, cell (i,k) equals the sum of valA[j]*valB[m] over every stored A non-zero j of row i and B non-zero m of column k with colA[j] equal to rowB[m]. Cells with no such pair read 0.
- R4: A row of A or a column of B whose two consecutive pointers are equal produces no pairs and costs a single cycle.
- R5: Every accepted start clears the whole result first, so a second run on unchanged operands gives the same result.
- R6: `busy` rises on the edge that accepts a start. It stays high for exactly DIM + nA*(DIM + nB) + 1 cycles, where nA and nB are the non-zero counts of A and B.
- R7: `done` is high for exactly one cycle, which is the last cycle of `busy`. `busy` is low on the following cycle.
- R8: While `busy` is high, start pulses and writes have no effect on the run length, on the result, or on the stored operands.
- R9: Products are 16x16 signed. They accumulate into 36-bit signed cells with no wrap, even for eight products of -32768*-32768 in one cell.
- R10: `rd_data` shows cell (`rd_row`,`rd_col`) combinationally, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiplication when idle |
| wr_en | input | 1 | Operand write strobe |
| wr_sel | input | 3 | Target vector code |
| wr_addr | input | 5 | Entry address in the target vector |
| wr_data | input | 16 | Write data; low bits used per vector |
| rd_row | input | 3 | Result row to read |
| rd_col | input | 3 | Result column to read |
| rd_data | output | 36 | Signed result cell |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps a dozen operand sets. These include all-zero operands, permutation-like patterns, operands with empty rows and empty columns, extreme negative values that need the full 36-bit range, and seeded random densities up to the 32 non-zero limit. A walker that mishandles equal pointers would either spend extra cycles or add a stray product, which shows up as a wrong run length or a non-zero cell. A missing clear at start would double every cell on the rerun. A narrow or unsigned accumulator would return wrapped or positive sums for the extreme set. An operand write accepted in mid-run would corrupt the follow-up rerun.

// File: rtl/spmm_pkg.sv
package spmm_pkg;

    typedef enum logic [2:0] {
        SEL_A_VAL = 3'd0,
        SEL_A_IDX = 3'd1,
        SEL_A_PTR = 3'd2,
        SEL_B_VAL = 3'd3,
        SEL_B_IDX = 3'd4,
        SEL_B_PTR = 3'd5
    } vec_sel_e;

    typedef enum logic [2:0] {
        WALK_IDLE,
        WALK_ROW,
        WALK_COL,
        WALK_PAIR,
        WALK_FIN
    } walk_e;

endpackage

// File: rtl/spmm_vec.sv
module spmm_vec #(
    parameter int DEPTH = 32,
    parameter int W     = 16,
    parameter int ADW   = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [ADW-1:0]            addr,
    input  logic [W-1:0]              data,
    output logic [DEPTH-1:0][W-1:0]   mem
);

    logic [DEPTH-1:0][W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we && (int'(addr) < DEPTH)) begin
            mem_d[addr] = data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign mem = mem_q;

endmodule

// File: rtl/spmm_ctrl.sv
module spmm_ctrl #(
    parameter  int DIM = 8,
    parameter  int NNZ = 32,
    localparam int IW  = $clog2(DIM),
    localparam int NW  = $clog2(NNZ),
    localparam int PW  = $clog2(NNZ + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [NNZ-1:0][IW-1:0]   a_idx,
    input  logic [NNZ-1:0][IW-1:0]   b_idx,
    input  logic [DIM:0][PW-1:0]     a_ptr,
    input  logic [DIM:0][PW-1:0]     b_ptr,
    output logic                     busy,
    output logic                     done,
    output logic                     clr,
    output logic                     hit,
    output logic [IW-1:0]            cur_i,
    output logic [IW-1:0]            cur_k,
    output logic [NW-1:0]            cur_j,
    output logic [NW-1:0]            cur_m
);
    import spmm_pkg::*;

    typedef struct packed {
        walk_e          st;
        logic [IW-1:0]  i;
        logic [IW-1:0]  k;
        logic [PW-1:0]  j;
        logic [PW-1:0]  jend;
        logic [PW-1:0]  m;
        logic [PW-1:0]  mend;
    } walk_t;

    walk_t w_d, w_q;
    logic adv_col, adv_j, adv_row;
    logic [IW:0] i_nx, k_nx;

    always_comb begin
        w_d     = w_q;
        clr     = 1'b0;
        hit     = 1'b0;
        adv_col = 1'b0;
        adv_j   = 1'b0;
        adv_row = 1'b0;
        i_nx    = {1'b0, w_q.i} + 1'b1;
        k_nx    = {1'b0, w_q.k} + 1'b1;
        case (w_q.st)
            WALK_IDLE: begin
                if (start) begin
                    clr    = 1'b1;
                    w_d.i  = '0;
                    w_d.st = WALK_ROW;
                end
            end
            WALK_ROW: begin
                w_d.j    = a_ptr[w_q.i];
                w_d.jend = a_ptr[i_nx];
                w_d.k    = '0;
                if (a_ptr[i_nx] <= a_ptr[w_q.i]) adv_row = 1'b1;
                else                              w_d.st = WALK_COL;
            end
            WALK_COL: begin
                w_d.m    = b_ptr[w_q.k];
                w_d.mend = b_ptr[k_nx];
                if (b_ptr[k_nx] <= b_ptr[w_q.k]) adv_col = 1'b1;
                else                              w_d.st = WALK_PAIR;
            end
            WALK_PAIR: begin
                hit   = (a_idx[w_q.j[NW-1:0]] == b_idx[w_q.m[NW-1:0]]);
                w_d.m = w_q.m + 1'b1;
                if (w_d.m >= w_q.mend) adv_col = 1'b1;
            end
            WALK_FIN: w_d.st = WALK_IDLE;
            default:  w_d.st = WALK_IDLE;
        endcase

        if (adv_col) begin
            if (w_q.k == IW'(DIM - 1)) begin
                adv_j = 1'b1;
            end else begin
                w_d.k  = w_q.k + 1'b1;
                w_d.st = WALK_COL;
            end
        end
        if (adv_j) begin
            w_d.j = w_q.j + 1'b1;
            if (w_d.j >= w_q.jend) begin
                adv_row = 1'b1;
            end else begin
                w_d.k  = '0;
                w_d.st = WALK_COL;
            end
        end
        if (adv_row) begin
            if (w_q.i == IW'(DIM - 1)) begin
                w_d.st = WALK_FIN;
            end else begin
                w_d.i  = w_q.i + 1'b1;
                w_d.st = WALK_ROW;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '{st: WALK_IDLE, default: '0};
        else        w_q <= w_d;
    end

    assign busy  = (w_q.st != WALK_IDLE);
    assign done  = (w_q.st == WALK_FIN);
    assign cur_i = w_q.i;
    assign cur_k = w_q.k;
    assign cur_j = w_q.j[NW-1:0];
    assign cur_m = w_q.m[NW-1:0];

endmodule

// File: rtl/spmm_acc.sv
module spmm_acc #(
    parameter  int DIM = 8,
    parameter  int VW  = 16,
    parameter  int CW  = 36,
    localparam int IW  = $clog2(DIM),
    localparam int CIW = $clog2(DIM * DIM)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic [IW-1:0]        row,
    input  logic [IW-1:0]        col,
    input  logic signed [VW-1:0] op_a,
    input  logic signed [VW-1:0] op_b,
    input  logic [IW-1:0]        rd_row,
    input  logic [IW-1:0]        rd_col,
    output logic [CW-1:0]        rd_data
);

    logic [DIM*DIM-1:0][CW-1:0] c_d, c_q;
    logic signed [2*VW-1:0]     prod;
    logic [CIW-1:0]             wr_idx, rd_idx;

    assign prod   = op_a * op_b;
    assign wr_idx = CIW'(int'(row) * DIM + int'(col));
    assign rd_idx = CIW'(int'(rd_row) * DIM + int'(rd_col));

    always_comb begin
        c_d = c_q;
        if (clr) begin
            c_d = '0;
        end else if (en) begin
            c_d[wr_idx] = c_q[wr_idx] + CW'(prod);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign rd_data = c_q[rd_idx];

endmodule

// File: rtl/spmm_csr_csc.sv
module spmm_csr_csc #(
    parameter  int DIM = 8,
    parameter  int NNZ = 32,
    parameter  int VW  = 16,
    parameter  int CW  = 36,
    localparam int IW  = $clog2(DIM),
    localparam int NW  = $clog2(NNZ),
    localparam int PW  = $clog2(NNZ + 1),
    localparam int ADW = NW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            wr_en,
    input  logic [2:0]      wr_sel,
    input  logic [ADW-1:0]  wr_addr,
    input  logic [VW-1:0]   wr_data,
    input  logic [IW-1:0]   rd_row,
    input  logic [IW-1:0]   rd_col,
    output logic [CW-1:0]   rd_data,
    output logic            busy,
    output logic            done
);
    import spmm_pkg::*;

    logic [NNZ-1:0][VW-1:0] a_val, b_val;
    logic [NNZ-1:0][IW-1:0] a_idx, b_idx;
    logic [DIM:0][PW-1:0]   a_ptr, b_ptr;
    logic                   wr_ok, acc_clr, acc_en;
    logic [IW-1:0]          cur_i, cur_k;
    logic [NW-1:0]          cur_j, cur_m;

    assign wr_ok = wr_en && !busy;

    spmm_vec #(.DEPTH(NNZ), .W(VW), .ADW(ADW)) u_a_val (
        .clk(clk), .rst_n(rst_n), .we(wr_ok && (wr_sel == SEL_A_VAL)),
        .addr(wr_addr), .data(wr_data), .mem(a_val));
    spmm_vec #(.DEPTH(NNZ), .W(IW), .ADW(ADW)) u_a_idx (
        .clk(clk), .rst_n(rst_n), .we(wr_ok && (wr_sel == SEL_A_IDX)),
        .addr(wr_addr), .data(wr_data[IW-1:0]), .mem(a_idx));
    spmm_vec #(.DEPTH(DIM + 1), .W(PW), .ADW(ADW)) u_a_ptr (
        .clk(clk), .rst_n(rst_n), .we(wr_ok && (wr_sel == SEL_A_PTR)),
        .addr(wr_addr), .data(wr_data[PW-1:0]), .mem(a_ptr));
    spmm_vec #(.DEPTH(NNZ), .W(VW), .ADW(ADW)) u_b_val (
        .clk(clk), .rst_n(rst_n), .we(wr_ok && (wr_sel == SEL_B_VAL)),
        .addr(wr_addr), .data(wr_data), .mem(b_val));
    spmm_vec #(.DEPTH(NNZ), .W(IW), .ADW(ADW)) u_b_idx (
        .clk(clk), .rst_n(rst_n), .we(wr_ok && (wr_sel == SEL_B_IDX)),
        .addr(wr_addr), .data(wr_data[IW-1:0]), .mem(b_idx));
    spmm_vec #(.DEPTH(DIM + 1), .W(PW), .ADW(ADW)) u_b_ptr (
        .clk(clk), .rst_n(rst_n), .we(wr_ok && (wr_sel == SEL_B_PTR)),
        .addr(wr_addr), .data(wr_data[PW-1:0]), .mem(b_ptr));

    spmm_ctrl #(.DIM(DIM), .NNZ(NNZ)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_idx(a_idx), .b_idx(b_idx), .a_ptr(a_ptr), .b_ptr(b_ptr),
        .busy(busy), .done(done), .clr(acc_clr), .hit(acc_en),
        .cur_i(cur_i), .cur_k(cur_k), .cur_j(cur_j), .cur_m(cur_m));

    spmm_acc #(.DIM(DIM), .VW(VW), .CW(CW)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr), .en(acc_en),
        .row(cur_i), .col(cur_k), .op_a(a_val[cur_j]), .op_b(b_val[cur_m]),
        .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data));

endmodule

// File: rtl/spmm_chk.sv
module spmm_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic acc_en
);

    AST_START_ENGAGES: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);                                  // R6
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);                                   // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                             // R7
    AST_DONE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);                                              // R7
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);                                             // R7
    AST_ACCUM_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |-> (busy && !done));                                 // R3

endmodule

bind spmm_csr_csc spmm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .done(done), .acc_en(acc_en));

// File: tb/spmm_csr_csc_bench.sv
`timescale 1ns/1ps
module spmm_csr_csc_bench;

    localparam int DIM = 8;
    localparam int NNZ = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_row = '0;
    logic [2:0]  rd_col = '0;
    logic [35:0] rd_data;
    logic        busy, done;

    int total = 0;
    int bad = 0;
    int clocks = 0;
    int ad[DIM][DIM];
    int bd[DIM][DIM];
    int na, nb;
    logic [31:0] seed = 32'h1badcafe;

    spmm_csr_csc u_spmm_csr_csc (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data),
        .busy(busy), .done(done));

    always #2.5 clk = ~clk;

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    always @(posedge clk) begin
        clocks++;
        if (clocks > 150000) begin
            bad++;
            $display("FAIL R6 watchdog: cycles=%0d limit=%0d", clocks, 150000);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int unsigned rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic wr(input int sel, input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_addr = 5'(addr); wr_data = 16'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic gen(input int p);
        int dens, v;
        for (int r = 0; r < DIM; r++)
            for (int c = 0; c < DIM; c++) begin ad[r][c] = 0; bd[r][c] = 0; end
        na = 0; nb = 0;
        if (p == 1) begin
            for (int i = 0; i < DIM; i++) begin
                ad[i][i] = i + 1;
                bd[DIM-1-i][i] = -(i + 2);
            end
        end else if (p == 2) begin
            for (int r = 0; r < 4; r++)
                for (int c = 0; c < DIM; c++) ad[r][c] = -32768;
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < DIM; r++) bd[r][c] = -32768;
        end else if (p == 3) begin
            ad[0][1] = 300; ad[0][6] = -7; ad[2][3] = 12345;
            ad[5][1] = -1;  ad[5][6] = 2;
            bd[1][1] = 4;   bd[6][1] = -9; bd[3][6] = 100; bd[1][6] = -32768;
        end else if (p >= 4) begin
            dens = 8 + p * 8;
            for (int r = 0; r < DIM; r++)
                for (int c = 0; c < DIM; c++)
                    if ((rnd() % 100) < dens && na < NNZ) begin
                        v = int'(rnd() % 65536) - 32768;
                        ad[r][c] = (v == 0) ? 5 : v;
                        na++;
                    end
            for (int c = 0; c < DIM; c++)
                for (int r = 0; r < DIM; r++)
                    if ((rnd() % 100) < dens && nb < NNZ) begin
                        v = int'(rnd() % 65536) - 32768;
                        bd[r][c] = (v == 0) ? -3 : v;
                        nb++;
                    end
        end
    endtask

    // R2: codes 0/1/2 = A value/column index/row pointer, 3/4/5 = B value/row index/column pointer
    task automatic load();
        int cnt;
        cnt = 0;
        for (int r = 0; r < DIM; r++) begin
            wr(2, r, cnt);
            for (int c = 0; c < DIM; c++)
                if (ad[r][c] != 0) begin
                    wr(0, cnt, ad[r][c]);
                    wr(1, cnt, c);
                    cnt++;
                end
        end
        wr(2, DIM, cnt);
        na = cnt;
        cnt = 0;
        for (int c = 0; c < DIM; c++) begin
            wr(5, c, cnt);
            for (int r = 0; r < DIM; r++)
                if (bd[r][c] != 0) begin
                    wr(3, cnt, bd[r][c]);
                    wr(4, cnt, r);
                    cnt++;
                end
        end
        wr(5, DIM, cnt);
        nb = cnt;
    endtask

    task automatic run(input bit inject, output int cyc, output int dn, output int busy_after);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0; dn = 0;
        while (busy) begin
            cyc++;
            if (done) dn++;
            if (inject && cyc == 4) begin
                start = 1'b1; wr_en = 1'b1; wr_sel = 3'd0; wr_addr = '0; wr_data = 16'h1234;
            end else begin
                start = 1'b0; wr_en = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0; wr_en = 1'b0;
        busy_after = int'(busy);
    endtask

    task automatic check_result(input int p);
        longint exp;
        for (int r = 0; r < DIM; r++)
            for (int c = 0; c < DIM; c++) begin
                exp = 0;
                for (int t = 0; t < DIM; t++)
                    exp += longint'(ad[r][t]) * longint'(bd[t][c]);
                rd_row = 3'(r); rd_col = 3'(c);
                #1;
                // R3 R9 R10: combinational read of each cell
                chk(longint'($signed(rd_data)) == exp, (p == 2) ? "R9" : "R3",
                    $sformatf("pattern %0d cell(%0d,%0d)", p, r, c),
                    longint'($signed(rd_data)), exp);
            end
    endtask

    task automatic check_run(input int p, input bit inject, input string req);
        int cyc, dn, ba, exp_cyc;
        run(inject, cyc, dn, ba);
        exp_cyc = DIM + na * (DIM + nb) + 1;
        chk(cyc == exp_cyc, (p == 3 || p == 0) ? "R4" : req,
            $sformatf("pattern %0d busy cycles", p), cyc, exp_cyc);     // R6
        chk(dn == 1, "R7", $sformatf("pattern %0d done count", p), dn, 1);
        chk(ba == 0, "R7", $sformatf("pattern %0d busy after done", p), ba, 0);
        check_result(p);
    endtask

    initial begin
        #12;
        // R1: reset state
        chk(busy == 1'b0, "R1", "busy at reset", busy, 0);
        chk(done == 1'b0, "R1", "done at reset", done, 0);
        for (int r = 0; r < DIM; r++)
            for (int c = 0; c < DIM; c++) begin
                rd_row = 3'(r); rd_col = 3'(c);
                #1;
                chk(rd_data == '0, "R1", "cell at reset", longint'(rd_data), 0);
            end
        @(negedge clk);
        rst_n = 1'b1;

        for (int p = 0; p < 12; p++) begin
            gen(p);
            load();
            if (p == 3) begin
                // R8: start and operand write during the run are ignored
                check_run(p, 1'b1, "R8");
                check_run(p, 1'b0, "R8");
            end else begin
                check_run(p, 1'b0, "R6");
            end
            if (p == 1 || p == 2) begin
                // R5: rerun without reload must not accumulate on top
                check_run(p, 1'b0, "R5");
            end
        end

        summary();
        $finish;
    end

endmodule